// File: doc/BRIEF.md
# I2C 10-bit address recognizer

This block is the slave-side address decoder of an I2C target. A bit-level front end shifts SDA in and delivers whole bytes with a one-cycle strobe, plus one-cycle pulses for START, repeated START and STOP. The recognizer watches the bytes that open each transfer. It decides whether the local slave is being addressed and which way the data will flow. It then raises an acknowledge request for every address byte it accepts.

Software configures a 10-bit address and a mode bit. In 7-bit mode the low seven bits of the configured address are compared with the upper seven bits of the opening byte. In 10-bit mode the opening byte must carry the `11110` prefix and the two high address bits, and a following byte must carry the low eight bits. After a complete 10-bit write addressing, the block remembers that it was addressed. A repeated START followed by the matching prefix with the read bit set then selects it for a read without a second address byte. This is the usual way a master reads back from a 10-bit slave.

All outputs are registered. Each one reflects a byte or event one clock after its strobe.

Top module: `i2c_addr_recog`

## Requirements
- R1: After synchronous reset `ack_req`, `selected`, `dir_read` and `match_done` are all 0, and no address phase is open until a START or repeated START arrives.
- R2: Bytes strobed before any START, or after the address phase of a transfer has ended, raise neither `ack_req` nor `match_done` and leave `selected` and `dir_read` unchanged.
- R3: In 7-bit mode, when the first byte after START or repeated START has bits [7:1] equal to `cfg_addr[6:0]`, the next cycle shows a one-cycle `ack_req` and `match_done`, `selected`=1, and `dir_read` equal to bit 0 of that byte (1 = master reads).
- R4: In 7-bit mode, a first byte whose bits [7:4] are `1111` never acknowledges or selects, even when `cfg_addr[6:0]` equals its bits [7:1]. It still ends the address phase with `match_done`.
- R5: In 10-bit mode, a first byte with bits [7:3]=`11110`, bits [2:1] equal to `cfg_addr[9:8]` and bit 0 = 0 gives a one-cycle `ack_req` with `selected`=0 and no `match_done`.
- R6: The byte after an R5 prefix is compared with `cfg_addr[7:0]`. On a match the next cycle shows `ack_req`, `match_done`, `selected`=1 and `dir_read`=0. On a mismatch it shows `match_done` alone, with no acknowledge.
- R7: A first byte with bits [7:3]=`11111` (reserved) never acknowledges or selects in either mode.
- R8: In 10-bit mode, a matching prefix with bit 0 = 1 acknowledges and selects with `dir_read`=1 only if a full 10-bit write match has been seen since the last STOP and no unselected address phase has followed. Otherwise it gives `match_done` alone.
- R9: The remembered addressed state is cleared by STOP and by any address phase that ends without selection.
- R10: STOP deasserts `selected` and `dir_read` and closes the address phase. START and repeated START deassert `selected` and `dir_read` and open a new address phase.
- R11: Every address phase that reaches a decision produces exactly one `match_done` pulse, whether or not the slave is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| cfg_addr | input | 10 | Local slave address; 7-bit mode uses bits [6:0] |
| rx_byte | input | 8 | Deserialized byte from the front end |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` valid |
| ev_start | input | 1 | START condition pulse |
| ev_rstart | input | 1 | Repeated START condition pulse |
| ev_stop | input | 1 | STOP condition pulse |
| ack_req | output | 1 | One-cycle request to acknowledge the byte just received |
| selected | output | 1 | Slave is addressed for the current transfer |
| dir_read | output | 1 | Transfer direction while selected, 1 = master reads |
| match_done | output | 1 | One-cycle pulse when the address phase is decided |

## Verification
The bench goes after the reserved `11111xx` range. A design that decoded only the prefix's two high address bits would acknowledge it. In 7-bit mode it checks the `1111xxx` range against a configured address that equals it, where a plain compare would wrongly select. It runs a read prefix with and without an earlier 10-bit write match, and after an unselected phase or a STOP in between. A design with a sticky or missing memory would then select when it must not, or refuse a legitimate read. It also feeds address-like data bytes after the address phase, where a decoder that re-arms itself would raise spurious acknowledges.

// File: rtl/addr_recog_pkg.sv
package addr_recog_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_DATA   = 2'd3
  } phase_e;

  typedef struct packed {
    logic ten_prefix;   // upper bits hold the 10-bit prefix pattern
    logic high_range;   // upper four bits all ones
    logic hi_match;     // embedded high address bits equal configured ones
    logic seven_match;  // upper seven bits equal configured 7-bit address
    logic low_match;    // whole byte equals configured low address byte
    logic rw;           // direction bit
  } byte_class_t;

endpackage

// File: rtl/addr_recog_classify.sv
module addr_recog_classify
  import addr_recog_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int A7_W    = 7,
  parameter int A10_W   = 10
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [A10_W-1:0]  addr,
  output byte_class_t       cls
);

  localparam int HI_W  = A10_W - BYTE_W;
  localparam int PFX_W = BYTE_W - 1 - HI_W;
  localparam logic [PFX_W-1:0] PFX_PATTERN = {{(PFX_W-1){1'b1}}, 1'b0};
  localparam logic [PFX_W-2:0] HIGH_ONES   = {(PFX_W-1){1'b1}};

  always_comb begin
    cls.ten_prefix  = (byte_in[BYTE_W-1 -: PFX_W] == PFX_PATTERN);
    cls.high_range  = (byte_in[BYTE_W-1 -: PFX_W-1] == HIGH_ONES);
    cls.hi_match    = (byte_in[HI_W:1] == addr[A10_W-1 -: HI_W]);
    cls.seven_match = (byte_in[BYTE_W-1:1] == addr[A7_W-1:0]);
    cls.low_match   = (byte_in == addr[BYTE_W-1:0]);
    cls.rw          = byte_in[0];
  end

endmodule

// File: rtl/addr_recog_memo.sv
module addr_recog_memo (
  input  logic clk,
  input  logic rst,
  input  logic clr_stop,
  input  logic clr_miss,
  input  logic set_hit,
  output logic memo_q
);

  always_ff @(posedge clk) begin
    if (rst || clr_stop || clr_miss) memo_q <= 1'b0;
    else if (set_hit)                memo_q <= 1'b1;
  end

endmodule

// File: rtl/addr_recog_fsm.sv
module addr_recog_fsm
  import addr_recog_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_ten_bit,
  input  logic        rx_valid,
  input  logic        ev_start,
  input  logic        ev_rstart,
  input  logic        ev_stop,
  input  byte_class_t cls,
  input  logic        memo_q,
  output phase_e      phase_q,
  output logic        ack_q,
  output logic        sel_q,
  output logic        dir_q,
  output logic        done_q,
  output logic        memo_set,
  output logic        memo_clr
);

  phase_e ph_d;
  logic   ack_d, sel_d, dir_d, done_d;

  always_comb begin
    ph_d     = phase_q;
    ack_d    = 1'b0;
    done_d   = 1'b0;
    sel_d    = sel_q;
    dir_d    = dir_q;
    memo_set = 1'b0;
    memo_clr = 1'b0;
    if (ev_stop) begin
      ph_d  = PH_IDLE;
      sel_d = 1'b0;
      dir_d = 1'b0;
    end else if (ev_start || ev_rstart) begin
      ph_d  = PH_FIRST;
      sel_d = 1'b0;
      dir_d = 1'b0;
    end else if (rx_valid) begin
      unique case (phase_q)
        PH_FIRST: begin
          ph_d   = PH_DATA;
          done_d = 1'b1;
          if (!cfg_ten_bit) begin
            if (cls.seven_match && !cls.high_range) begin
              ack_d = 1'b1;
              sel_d = 1'b1;
              dir_d = cls.rw;
            end else begin
              memo_clr = 1'b1;
            end
          end else if (cls.ten_prefix && cls.hi_match) begin
            if (!cls.rw) begin
              ph_d   = PH_SECOND;
              done_d = 1'b0;
              ack_d  = 1'b1;
            end else if (memo_q) begin
              ack_d = 1'b1;
              sel_d = 1'b1;
              dir_d = 1'b1;
            end else begin
              memo_clr = 1'b1;
            end
          end else begin
            memo_clr = 1'b1;
          end
        end
        PH_SECOND: begin
          ph_d   = PH_DATA;
          done_d = 1'b1;
          if (cls.low_match) begin
            ack_d    = 1'b1;
            sel_d    = 1'b1;
            dir_d    = 1'b0;
            memo_set = 1'b1;
          end else begin
            memo_clr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
      sel_q   <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= ph_d;
      ack_q   <= ack_d;
      sel_q   <= sel_d;
      dir_q   <= dir_d;
      done_q  <= done_d;
    end
  end

endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import addr_recog_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int A7_W   = 7,
  parameter int A10_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ten_bit,
  input  logic [A10_W-1:0]  cfg_addr,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  output logic              ack_req,
  output logic              selected,
  output logic              dir_read,
  output logic              match_done
);

  byte_class_t cls;
  phase_e      phase_q;
  logic        memo_q, memo_set, memo_clr;

  addr_recog_classify #(
    .BYTE_W(BYTE_W), .A7_W(A7_W), .A10_W(A10_W)
  ) u_classify (
    .byte_in (rx_byte),
    .addr    (cfg_addr),
    .cls     (cls)
  );

  addr_recog_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cfg_ten_bit(cfg_ten_bit),
    .rx_valid   (rx_valid),
    .ev_start   (ev_start),
    .ev_rstart  (ev_rstart),
    .ev_stop    (ev_stop),
    .cls        (cls),
    .memo_q     (memo_q),
    .phase_q    (phase_q),
    .ack_q      (ack_req),
    .sel_q      (selected),
    .dir_q      (dir_read),
    .done_q     (match_done),
    .memo_set   (memo_set),
    .memo_clr   (memo_clr)
  );

  addr_recog_memo u_memo (
    .clk     (clk),
    .rst     (rst),
    .clr_stop(ev_stop),
    .clr_miss(memo_clr),
    .set_hit (memo_set),
    .memo_q  (memo_q)
  );

endmodule

// File: rtl/i2c_addr_recog_chk.sv
module i2c_addr_recog_chk
  import addr_recog_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cfg_ten_bit,
  input logic [7:0] rx_byte,
  input logic       rx_valid,
  input logic       ev_start,
  input logic       ev_rstart,
  input logic       ev_stop,
  input logic       ack_req,
  input logic       selected,
  input logic       dir_read,
  input logic       match_done,
  input phase_e     phase
);

  logic quiet;
  assign quiet = !ev_start && !ev_rstart && !ev_stop;

  assert_reserved_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FIRST && rx_valid && quiet && rx_byte[7:3] == 5'b11111)
      |=> (!ack_req && !selected));

  assert_high_range_7bit_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_ten_bit && phase == PH_FIRST && rx_valid && quiet && rx_byte[7:4] == 4'hF)
      |=> (!selected && !ack_req && match_done));

  assert_stop_deselects_R10: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (!selected && !dir_read && !ack_req && !match_done));

  assert_start_deselects_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_start || ev_rstart) |=> !selected);

  assert_ack_follows_byte_R2: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> $past(rx_valid));

  assert_select_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(selected) |-> (ack_req && match_done));

  assert_no_select_mid_10bit_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SECOND) |-> (!selected && !match_done));

  assert_dir_needs_select_R3: assert property (@(posedge clk) disable iff (rst)
    dir_read |-> selected);

endmodule

bind i2c_addr_recog i2c_addr_recog_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_ten_bit(cfg_ten_bit),
  .rx_byte    (rx_byte),
  .rx_valid   (rx_valid),
  .ev_start   (ev_start),
  .ev_rstart  (ev_rstart),
  .ev_stop    (ev_stop),
  .ack_req    (ack_req),
  .selected   (selected),
  .dir_read   (dir_read),
  .match_done (match_done),
  .phase      (phase_q)
);

// File: tb/test_i2c_addr_recog.sv
module test_i2c_addr_recog;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_ten_bit = 1'b1;
  logic [9:0] cfg_addr = 10'h2A5;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_valid = 1'b0;
  logic       ev_start = 1'b0;
  logic       ev_rstart = 1'b0;
  logic       ev_stop = 1'b0;
  logic       ack_req, selected, dir_read, match_done;

  int n_vec = 0;
  int n_bad = 0;

  // bench model state: 0 idle, 1 first byte, 2 second byte, 3 data
  int   m_phase = 0;
  logic m_memo = 1'b0;
  logic m_sel = 1'b0;
  logic m_dir = 1'b0;

  always #5 clk = ~clk;

  i2c_addr_recog i_i2c_addr_recog (
    .clk        (clk),
    .rst        (rst),
    .cfg_ten_bit(cfg_ten_bit),
    .cfg_addr   (cfg_addr),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .ev_start   (ev_start),
    .ev_rstart  (ev_rstart),
    .ev_stop    (ev_stop),
    .ack_req    (ack_req),
    .selected   (selected),
    .dir_read   (dir_read),
    .match_done (match_done)
  );

  task automatic compare(input logic [3:0] exp, input string tag);
    logic [3:0] got;
    got = {ack_req, selected, dir_read, match_done};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: ack/sel/dir/done got %b expected %b", tag, got, exp);
    end
  endtask

  // kind: 0 byte, 1 start, 2 repeated start, 3 stop
  task automatic step(input int kind, input logic [7:0] b, input string tag);
    logic e_ack, e_done;
    e_ack = 1'b0;
    e_done = 1'b0;
    rx_byte   = b;
    rx_valid  = (kind == 0);
    ev_start  = (kind == 1);
    ev_rstart = (kind == 2);
    ev_stop   = (kind == 3);
    if (kind == 3) begin
      m_phase = 0; m_sel = 0; m_dir = 0; m_memo = 0;
    end else if (kind != 0) begin
      m_phase = 1; m_sel = 0; m_dir = 0;
    end else if (m_phase == 1) begin
      m_phase = 3;
      e_done = 1'b1;
      if (!cfg_ten_bit) begin
        if (b[7:4] != 4'hF && b[7:1] == cfg_addr[6:0]) begin
          e_ack = 1; m_sel = 1; m_dir = b[0];
        end else m_memo = 0;
      end else if (b[7:3] == 5'b11110 && b[2:1] == cfg_addr[9:8]) begin
        if (!b[0]) begin
          m_phase = 2; e_done = 0; e_ack = 1;
        end else if (m_memo) begin
          e_ack = 1; m_sel = 1; m_dir = 1;
        end else m_memo = 0;
      end else m_memo = 0;
    end else if (m_phase == 2) begin
      m_phase = 3;
      e_done = 1'b1;
      if (b == cfg_addr[7:0]) begin
        e_ack = 1; m_sel = 1; m_dir = 0; m_memo = 1;
      end else m_memo = 0;
    end
    @(negedge clk);
    rx_valid = 0; ev_start = 0; ev_rstart = 0; ev_stop = 0;
    compare({e_ack, m_sel, m_dir, e_done}, tag);
  endtask

  function automatic logic [7:0] pick_byte();
    logic [7:0] pw;
    pw = {5'b11110, cfg_addr[9:8], 1'b0};
    case ($urandom % 7)
      0: return pw;
      1: return pw | 8'h01;
      2: return cfg_addr[7:0];
      3: return {cfg_addr[6:0], 1'($urandom % 2)};
      4: return {5'b11111, 3'($urandom % 8)};
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare(4'b0000, "R1 reset state");
    // 10-bit mode, address 0x2A5: prefix write 0xF4, read 0xF5, low byte 0xA5
    step(0, 8'hF4, "R2 byte before any START ignored");
    step(1, 8'h00, "R10 START opens phase");
    step(0, 8'hF4, "R5 prefix write acknowledged, not selected");
    step(0, 8'hA5, "R6 low byte match selects for write");
    step(0, 8'hF4, "R2 data byte after phase ignored");
    step(2, 8'h00, "R10 repeated START deselects");
    step(0, 8'hF5, "R8 remembered read selects");
    step(3, 8'h00, "R10 STOP deselects");
    step(1, 8'h00, "R10 START");
    step(0, 8'hF5, "R9 read after STOP refused");
    step(1, 8'h00, "R10 START");
    step(0, 8'hF4, "R5 prefix");
    step(0, 8'hA4, "R6 low byte mismatch");
    step(1, 8'h00, "R10 START");
    step(0, 8'hFC, "R7 reserved prefix silent");
    step(1, 8'h00, "R10 START");
    step(0, 8'hF0, "R11 wrong high bits ends phase");
    step(1, 8'h00, "R10 START");
    step(0, 8'hF4, "R5 prefix");
    step(0, 8'hA5, "R6 match");
    step(2, 8'h00, "R10 repeated START");
    step(0, 8'h12, "R9 unselected phase clears memory");
    step(2, 8'h00, "R10 repeated START");
    step(0, 8'hF5, "R9 read refused after miss");
    // 7-bit mode
    step(3, 8'h00, "R10 STOP");
    cfg_ten_bit = 1'b0;
    cfg_addr = 10'h025;
    step(1, 8'h00, "R10 START");
    step(0, 8'h4A, "R3 7-bit write match");
    step(2, 8'h00, "R10 repeated START");
    step(0, 8'h4B, "R3 7-bit read match");
    step(0, 8'h4B, "R2 data byte ignored");
    step(3, 8'h00, "R10 STOP");
    cfg_addr = 10'h07A;
    step(1, 8'h00, "R10 START");
    step(0, 8'hF4, "R4 1111xxx never matches in 7-bit mode");
    step(1, 8'h00, "R10 START");
    step(0, 8'hFD, "R7 reserved silent in 7-bit mode");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) begin
        if ($urandom % 2 == 0) begin
          cfg_ten_bit = 1'($urandom % 2);
          cfg_addr = 10'($urandom);
        end
        step(3, 8'h00, "R10 random STOP");
      end else if (r <= 2) step(1, 8'h00, "R10 random START");
      else if (r == 3) step(2, 8'h00, "R8 random repeated START");
      else step(0, pick_byte(), "R11 random byte");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule